// File: doc/BRIEF.md
# Paired Mailbox Bank with Shared Interrupt Routing

This block gives processors on a chip a small set of one-word mailboxes for passing short messages. Each mailbox is a 32-bit register whose top bit is its occupancy flag and whose lower 31 bits are the message. A sender posts by writing a word with the top bit set. The receiver frees the slot by writing a word with the top bit clear. Mailboxes are used two at a time: the two indices of a pair differ only in bit 0, and each member of the pair carries one direction of traffic.

Every mailbox drives a dedicated "holding a message" interrupt and a dedicated "slot free" interrupt. Each one has its own enable register inside the mailbox's window. The same gated events also feed a set of shared interrupt lines. Each shared line has a mask register: one byte selects the free events of mailboxes 0..7, and the next byte selects their occupancy events. A read-only configuration word reports how many mailboxes, semaphores, doorbells and shared lines the unit has.

All access goes through a request/response register port. A request moves when `req_valid` and `req_ready` are both high. A read returns its data on `rsp_valid` in the cycle after it is accepted, and that data is held until `rsp_ready` is seen. `req_ready` is low while an unconsumed response is waiting, so the port never holds more than one response. Writes produce no response.

Top module: `mbox_bank`

## Requirements
- R1: After reset, every mailbox reads 0. Every per-mailbox enable reads 0 and every shared mask reads 0. All interrupt outputs are low and `rsp_valid` is low.
- R2: A write to mailbox n's data register (byte address 0x10000 + 0x8000*n) whose bit 31 is 1 stores the whole word. A later read returns exactly that word, and bit 31 marks the mailbox full.
- R3: A write to a mailbox data register whose bit 31 is 0 stores that word, which marks the mailbox empty. From the cycle after acceptance, that mailbox's full interrupt is low.
- R4: `irq_full[n]` is high exactly while mailbox n holds bit 31 = 1 and its full enable (window offset 0x4, bit 0) is 1. `irq_empty[n]` is high exactly while bit 31 = 0 and its empty enable (window offset 0x8, bit 0) is 1. Neither output depends on the shared masks.
- R5: The per-mailbox enable registers keep only bit 0 of the written word, and all their other bits read 0.
- R6: The mask for shared line s is at 0x100 + 4*s. Bit k (k = 0..7) routes mailbox k's empty event and bit 8+k routes its full event. `irq_shared[s]` is the OR of the routed events. Bits 31:16 and bits for absent mailboxes read 0.
- R7: The read-only word at 0x380 holds the mailbox count in bits 3:0, shared-semaphore count in 7:4, arbitrated-semaphore count in 11:8, doorbell count in 15:12 and shared-line count in 19:16. Writes to it have no effect.
- R8: A read of an unmapped address (including mask slots past the last shared line and unused mailbox window offsets) returns 0. A write to one changes no register.
- R9: Writing one mailbox changes neither its pair partner nor any other mailbox.
- R10: Read data appears with `rsp_valid` one cycle after acceptance. While `rsp_valid` is high and `rsp_ready` is low, the data stays stable and `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (20) | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes the read data |
| rsp_rdata | output | 32 | Read data |
| irq_full | output | NUM_MBOX | Dedicated full interrupts, one per mailbox |
| irq_empty | output | NUM_MBOX | Dedicated empty interrupts, one per mailbox |
| irq_shared | output | NUM_SHARED | Shared interrupt lines |

## Verification
A write takes effect at the rising edge that accepts it. The interrupt outputs are built from registers with no further staging, so they show the new state in that same cycle. Read data is due on `rsp_valid` exactly one cycle after acceptance. Each bench operation drives its request at a falling edge and releases it at the next falling edge, then samples read data and all three interrupt vectors there, half a cycle after the accepting edge. The back-pressure test samples across several stalled cycles to confirm that the data is held and `req_ready` stays low.

// File: rtl/mbox_bank_pkg.sv
package mbox_bank_pkg;

  localparam int ADDR_W    = 20;
  localparam int DATA_W    = 32;
  localparam int MBOX_MAX  = 8;
  localparam int LINE_MAX  = 16;
  localparam int MASK_W    = 2 * MBOX_MAX;

  localparam logic [ADDR_W-1:0] CFG_ADDR = 20'h00380;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_WORD,
    RG_EN_FULL,
    RG_EN_EMPTY,
    RG_MASK,
    RG_CFG
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [3:0] idx;
  } reg_sel_t;

  // Address decode: mailbox windows are 32 KiB apart starting at 64 KiB,
  // common registers sit below 64 KiB.
  function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a,
                                           input int n_mbox,
                                           input int n_line);
    reg_sel_t   s;
    logic [4:0] win;
    s.kind = RG_NONE;
    s.idx  = '0;
    win    = a[19:15];
    if (a[19:16] != 4'd0) begin
      if (win >= 5'd2 && (int'(win) - 2) < n_mbox &&
          a[14:4] == 11'd0 && a[1:0] == 2'd0) begin
        s.idx = 4'(win - 5'd2);
        case (a[3:2])
          2'd0:    s.kind = RG_WORD;
          2'd1:    s.kind = RG_EN_FULL;
          2'd2:    s.kind = RG_EN_EMPTY;
          default: s.kind = RG_NONE;
        endcase
      end
    end else if (a == CFG_ADDR) begin
      s.kind = RG_CFG;
    end else if (a[19:8] == 12'h001 && a[7:6] == 2'd0 && a[1:0] == 2'd0 &&
                 int'(a[5:2]) < n_line) begin
      s.kind = RG_MASK;
      s.idx  = a[5:2];
    end
    return s;
  endfunction

endpackage

// File: rtl/mbox_slot.sv
module mbox_slot
  import mbox_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_word,
  input  logic              wr_en_full,
  input  logic              wr_en_empty,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] word_q,
  output logic              en_full_q,
  output logic              en_empty_q,
  output logic              evt_full,
  output logic              evt_empty
);

  localparam int FLAG_BIT = DATA_W - 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q     <= '0;
      en_full_q  <= 1'b0;
      en_empty_q <= 1'b0;
    end else begin
      if (wr_word)     word_q     <= wdata;
      if (wr_en_full)  en_full_q  <= wdata[0];
      if (wr_en_empty) en_empty_q <= wdata[0];
    end
  end

  // Level events: occupancy flag qualified by the matching enable.
  assign evt_full  =  word_q[FLAG_BIT] & en_full_q;
  assign evt_empty = ~word_q[FLAG_BIT] & en_empty_q;

  AST_POST_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_word && wdata[FLAG_BIT]) |=> (word_q[FLAG_BIT] && word_q[FLAG_BIT-1:0] == $past(wdata[FLAG_BIT-1:0]))); // R2

  AST_CLEAR_DROPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_word && !wdata[FLAG_BIT]) |=> !evt_full); // R3

  AST_FULL_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_full) |-> ($past(wr_word) || $past(wr_en_full))); // R4

  AST_QUIET_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_word |=> $stable(word_q)); // R9

endmodule

// File: rtl/mbox_share_line.sv
module mbox_share_line
  import mbox_bank_pkg::*;
#(
  parameter int NUM_MBOX = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_mask,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_MBOX-1:0] evt_full,
  input  logic [NUM_MBOX-1:0] evt_empty,
  output logic [MASK_W-1:0] mask_q,
  output logic              line
);

  // Writable bits: empty byte low, full byte high, only present mailboxes.
  localparam logic [MBOX_MAX-1:0] PRESENT  = MBOX_MAX'((1 << NUM_MBOX) - 1);
  localparam logic [MASK_W-1:0]   KEEP     = {PRESENT, PRESENT};

  logic [MASK_W-1:0] events;

  always_comb begin
    events = '0;
    events[NUM_MBOX-1:0]            = evt_empty;
    events[MBOX_MAX +: NUM_MBOX]    = evt_full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= wdata[MASK_W-1:0] & KEEP;
  end

  assign line = |(events & mask_q);

  AST_LINE_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    line |-> (mask_q != '0)); // R6

  AST_LINE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    line |-> ((evt_full != '0) || (evt_empty != '0))); // R6

endmodule

// File: rtl/mbox_bank.sv
module mbox_bank
  import mbox_bank_pkg::*;
#(
  parameter int NUM_MBOX   = 8,
  parameter int NUM_SHARED = 4,
  parameter int NUM_SSEM   = 8,
  parameter int NUM_ASEM   = 8,
  parameter int NUM_DBELL  = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic [NUM_MBOX-1:0]   irq_full,
  output logic [NUM_MBOX-1:0]   irq_empty,
  output logic [NUM_SHARED-1:0] irq_shared
);

  localparam logic [DATA_W-1:0] CFG_WORD = {12'd0,
                                            4'(NUM_SHARED), 4'(NUM_DBELL),
                                            4'(NUM_ASEM), 4'(NUM_SSEM),
                                            4'(NUM_MBOX)};

  reg_sel_t          sel;
  logic              fire;
  logic              wr_fire;
  logic              rd_fire;
  logic [DATA_W-1:0] rd_word;

  logic [DATA_W-1:0] slot_word  [NUM_MBOX];
  logic              slot_enf   [NUM_MBOX];
  logic              slot_ene   [NUM_MBOX];
  logic [MASK_W-1:0] line_mask  [NUM_SHARED];

  assign sel       = decode_addr(req_addr, NUM_MBOX, NUM_SHARED);
  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign wr_fire   = fire && req_write;
  assign rd_fire   = fire && !req_write;

  for (genvar n = 0; n < NUM_MBOX; n++) begin : g_slot
    logic hit;
    assign hit = (sel.idx == 4'(n));
    mbox_slot u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_word     (wr_fire && hit && sel.kind == RG_WORD),
      .wr_en_full  (wr_fire && hit && sel.kind == RG_EN_FULL),
      .wr_en_empty (wr_fire && hit && sel.kind == RG_EN_EMPTY),
      .wdata       (req_wdata),
      .word_q      (slot_word[n]),
      .en_full_q   (slot_enf[n]),
      .en_empty_q  (slot_ene[n]),
      .evt_full    (irq_full[n]),
      .evt_empty   (irq_empty[n])
    );
  end

  for (genvar s = 0; s < NUM_SHARED; s++) begin : g_line
    mbox_share_line #(.NUM_MBOX(NUM_MBOX)) u_line (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_mask   (wr_fire && sel.kind == RG_MASK && sel.idx == 4'(s)),
      .wdata     (req_wdata),
      .evt_full  (irq_full),
      .evt_empty (irq_empty),
      .mask_q    (line_mask[s]),
      .line      (irq_shared[s])
    );
  end

  always_comb begin
    rd_word = '0;
    case (sel.kind)
      RG_WORD:     for (int n = 0; n < NUM_MBOX; n++)
                     if (sel.idx == 4'(n)) rd_word = slot_word[n];
      RG_EN_FULL:  for (int n = 0; n < NUM_MBOX; n++)
                     if (sel.idx == 4'(n)) rd_word = {31'd0, slot_enf[n]};
      RG_EN_EMPTY: for (int n = 0; n < NUM_MBOX; n++)
                     if (sel.idx == 4'(n)) rd_word = {31'd0, slot_ene[n]};
      RG_MASK:     for (int s = 0; s < NUM_SHARED; s++)
                     if (sel.idx == 4'(s)) rd_word = {16'd0, line_mask[s]};
      RG_CFG:      rd_word = CFG_WORD;
      default:     rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (rd_fire) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_word;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata))); // R10

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready); // R10

  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rsp_valid); // R10

endmodule

// File: tb/mbox_bank_bench.sv
module mbox_bank_bench;

  typedef struct packed {
    logic        wr;
    logic [19:0] addr;
    logic [31:0] data;
    logic [31:0] exp_rd;
    logic [7:0]  exp_full;
    logic [7:0]  exp_empty;
    logic [3:0]  exp_shr;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 20'h10000, 32'h0,        32'h0,        8'h00, 8'h00, 4'h0, 4'd1},  // R1 idle empty, no irq
    '{1'b1, 20'h10008, 32'h1,        32'h0,        8'h00, 8'h01, 4'h0, 4'd4},  // R4 empty enable
    '{1'b1, 20'h10000, 32'h80001234, 32'h0,        8'h00, 8'h00, 4'h0, 4'd2},  // R2 post
    '{1'b0, 20'h10000, 32'h0,        32'h80001234, 8'h00, 8'h00, 4'h0, 4'd2},  // R2 readback
    '{1'b1, 20'h10004, 32'h1,        32'h0,        8'h01, 8'h00, 4'h0, 4'd4},  // R4 full enable
    '{1'b0, 20'h10004, 32'h0,        32'h1,        8'h01, 8'h00, 4'h0, 4'd5},  // R5
    '{1'b0, 20'h10008, 32'h0,        32'h1,        8'h01, 8'h00, 4'h0, 4'd5},  // R5
    '{1'b1, 20'h00108, 32'h100,      32'h0,        8'h01, 8'h00, 4'h4, 4'd6},  // R6 line2 <- full0
    '{1'b1, 20'h10000, 32'h55,       32'h0,        8'h00, 8'h01, 4'h0, 4'd3},  // R3 empty it
    '{1'b0, 20'h10000, 32'h0,        32'h55,       8'h00, 8'h01, 4'h0, 4'd3},  // R3 payload kept
    '{1'b1, 20'h00108, 32'hFFFFFFFF, 32'h0,        8'h00, 8'h01, 4'h4, 4'd6},  // R6 all bits
    '{1'b0, 20'h00108, 32'h0,        32'h0000FFFF, 8'h00, 8'h01, 4'h4, 4'd6},  // R6 upper reads 0
    '{1'b1, 20'h18000, 32'h80000007, 32'h0,        8'h00, 8'h01, 4'h4, 4'd4},  // R4 no enable no irq
    '{1'b0, 20'h18000, 32'h0,        32'h80000007, 8'h00, 8'h01, 4'h4, 4'd2},  // R2
    '{1'b0, 20'h10000, 32'h0,        32'h55,       8'h00, 8'h01, 4'h4, 4'd9},  // R9 partner untouched
    '{1'b1, 20'h18004, 32'h1,        32'h0,        8'h02, 8'h01, 4'h4, 4'd4},  // R4
    '{1'b0, 20'h00380, 32'h0,        32'h00047888, 8'h02, 8'h01, 4'h4, 4'd7},  // R7
    '{1'b1, 20'h00380, 32'h0,        32'h0,        8'h02, 8'h01, 4'h4, 4'd7},  // R7 write ignored
    '{1'b0, 20'h00380, 32'h0,        32'h00047888, 8'h02, 8'h01, 4'h4, 4'd7},  // R7
    '{1'b0, 20'h00200, 32'h0,        32'h0,        8'h02, 8'h01, 4'h4, 4'd8},  // R8
    '{1'b1, 20'h1000C, 32'hFFFFFFFF, 32'h0,        8'h02, 8'h01, 4'h4, 4'd8},  // R8 unmapped write
    '{1'b0, 20'h10000, 32'h0,        32'h55,       8'h02, 8'h01, 4'h4, 4'd8},  // R8
    '{1'b0, 20'h1000C, 32'h0,        32'h0,        8'h02, 8'h01, 4'h4, 4'd8},  // R8
    '{1'b1, 20'h00104, 32'h200,      32'h0,        8'h02, 8'h01, 4'h6, 4'd6},  // R6 line1 <- full1
    '{1'b1, 20'h00108, 32'h0,        32'h0,        8'h02, 8'h01, 4'h2, 4'd4},  // R4 dedicated kept
    '{1'b1, 20'h10008, 32'h0,        32'h0,        8'h02, 8'h00, 4'h2, 4'd4},  // R4
    '{1'b1, 20'h48000, 32'h80000000, 32'h0,        8'h02, 8'h00, 4'h2, 4'd2},  // R2 last box
    '{1'b1, 20'h48004, 32'h1,        32'h0,        8'h82, 8'h00, 4'h2, 4'd4},  // R4
    '{1'b0, 20'h48000, 32'h0,        32'h80000000, 8'h82, 8'h00, 4'h2, 4'd2},  // R2
    '{1'b1, 20'h0010C, 32'h00800000, 32'h0,        8'h82, 8'h00, 4'h2, 4'd6},  // R6 reserved bit
    '{1'b0, 20'h0010C, 32'h0,        32'h0,        8'h82, 8'h00, 4'h2, 4'd6},  // R6
    '{1'b0, 20'h00110, 32'h0,        32'h0,        8'h82, 8'h00, 4'h2, 4'd8},  // R8 line past last
    '{1'b1, 20'h18000, 32'h7,        32'h0,        8'h80, 8'h00, 4'h0, 4'd3},  // R3 drop full1
    '{1'b1, 20'h00104, 32'h8000,     32'h0,        8'h80, 8'h00, 4'h2, 4'd6},  // R6 line1 <- full7
    '{1'b1, 20'h10004, 32'h7,        32'h0,        8'h80, 8'h00, 4'h2, 4'd4},  // R4 box0 empty
    '{1'b0, 20'h10004, 32'h0,        32'h1,        8'h80, 8'h00, 4'h2, 4'd5}   // R5 only bit0
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic [7:0]  irq_full;
  logic [7:0]  irq_empty;
  logic [3:0]  irq_shared;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  mbox_bank u_mbox_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_rdata  (rsp_rdata),
    .irq_full   (irq_full),
    .irq_empty  (irq_empty),
    .irq_shared (irq_shared)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_op(input logic wr, input logic [19:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports
    check("R1 irq_full",   {24'd0, irq_full},   32'h0);
    check("R1 irq_empty",  {24'd0, irq_empty},  32'h0);
    check("R1 irq_shared", {28'd0, irq_shared}, 32'h0);
    check("R1 rsp_valid",  {31'd0, rsp_valid},  32'h0);
    check("R10 req_ready idle", {31'd0, req_ready}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      bus_op(VECS[i].wr, VECS[i].addr, VECS[i].data);
      if (!VECS[i].wr) begin
        check($sformatf("R%0d vec %0d rsp_valid", VECS[i].req, i), {31'd0, rsp_valid}, 32'h1);
        check($sformatf("R%0d vec %0d rdata", VECS[i].req, i), rsp_rdata, VECS[i].exp_rd);
      end
      check($sformatf("R%0d vec %0d irq_full", VECS[i].req, i), {24'd0, irq_full}, {24'd0, VECS[i].exp_full});
      check($sformatf("R%0d vec %0d irq_empty", VECS[i].req, i), {24'd0, irq_empty}, {24'd0, VECS[i].exp_empty});
      check($sformatf("R%0d vec %0d irq_shared", VECS[i].req, i), {28'd0, irq_shared}, {28'd0, VECS[i].exp_shr});
    end

    // R10 back-pressure: hold the response, stall the next request
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1;
    req_write = 1'b0;
    req_addr  = 20'h48000;
    @(negedge clk);
    req_addr  = 20'h18004;
    for (int k = 0; k < 3; k++) begin
      check("R10 stalled rsp_valid", {31'd0, rsp_valid}, 32'h1);
      check("R10 stalled rdata", rsp_rdata, 32'h80000000);
      check("R10 stalled req_ready", {31'd0, req_ready}, 32'h0);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 next rdata", rsp_rdata, 32'h1);
    check("R10 next rsp_valid", {31'd0, rsp_valid}, 32'h1);
    @(negedge clk);
    check("R10 drained", {31'd0, rsp_valid}, 32'h0);

    // R1 reset in mid-run clears everything
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 irq_full after reset", {24'd0, irq_full}, 32'h0);
    check("R1 irq_shared after reset", {28'd0, irq_shared}, 32'h0);
    bus_op(1'b0, 20'h48000, 32'h0);
    check("R1 mailbox word after reset", rsp_rdata, 32'h0);
    bus_op(1'b0, 20'h48004, 32'h0);
    check("R1 full enable after reset", rsp_rdata, 32'h0);
    bus_op(1'b0, 20'h00104, 32'h0);
    check("R1 shared mask after reset", rsp_rdata, 32'h0);
    bus_op(1'b1, 20'h18008, 32'h1);
    check("R4 empty irq on fresh box", {24'd0, irq_empty}, 32'h02);

    finish_run();
  end

endmodule